// File: doc/BRIEF.md
# Operand Shifter for a 32-bit Datapath

This combinational block builds the second operand of a data-processing operation, together with a shifter carry that the flag logic uses for logical operations. It has three operand sources. The first is a rotated constant: a byte rotated right by twice a 4-bit rotate field. The second is a register value shifted by a 5-bit amount taken from the instruction. The third is a register value shifted by an amount held in the low byte of a second register.

The shift kinds are logical left, logical right, arithmetic right and rotate right. For amounts that come from the instruction, a field of zero has a special meaning for the right shifts. A zero field on a logical or arithmetic right shift means a shift by 32. A zero field on a rotate selects a one-bit rotate through the incoming carry. For amounts that come from a register, the block handles amounts from 0 to 255.

Top module: `opshift_unit`

## Requirements
- R1: With `op_sel` = 00, `operand` is `imm_byte` zero-extended to 32 bits and rotated right by 2 × `imm_rot` bit positions.
- R2: With `op_sel` = 00, `carry_out` equals `carry_in` when `imm_rot` is 0. Otherwise it equals bit 31 of `operand`.
- R3: Shift kind codes are 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. With `op_sel` = 01 and kind 00, an `sh_imm` of 1 to 31 shifts `reg_val` left and sets `carry_out` to the last bit shifted out. An `sh_imm` of 0 passes `reg_val` and `carry_in` through unchanged.
- R4: With `op_sel` = 01 and kind 01 or 10, an `sh_imm` of 1 to 31 shifts right by that amount and `carry_out` is the last bit shifted out. An `sh_imm` of 0 means a shift by 32. For kind 01 this gives 0. For kind 10 this gives 32 copies of bit 31. In both cases `carry_out` is `reg_val[31]`.
- R5: With `op_sel` = 01 and kind 11, an `sh_imm` of 1 to 31 rotates `reg_val` right and `carry_out` is bit 31 of the result.
- R6: With `op_sel` = 01, kind 11 and `sh_imm` = 0, `operand` is `{carry_in, reg_val[31:1]}` and `carry_out` is `reg_val[0]`.
- R7: With `op_sel` = 10 or 11, the shift amount is `amt_reg[7:0]`. Bits 31:8 of `amt_reg`, `sh_imm`, `imm_byte` and `imm_rot` have no effect.
- R8: A register amount of 0 passes `reg_val` and `carry_in` through unchanged for every kind.
- R9: For a register amount, kinds 00 and 01 follow these rules. At exactly 32 the result is 0, with `carry_out` equal to `reg_val[0]` for kind 00 and `reg_val[31]` for kind 01. Above 32 the result is 0 and `carry_out` is 0. Below 32 the shift is normal and `carry_out` is the last bit shifted out.
- R10: For a register amount of 32 or more with kind 10, every bit of `operand` and `carry_out` equal `reg_val[31]`.
- R11: For a nonzero register amount with kind 11, the rotation is the amount modulo 32 and `carry_out` is bit 31 of the result. A nonzero multiple of 32 therefore leaves `reg_val` unchanged with `carry_out` = `reg_val[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Source: 00 rotated constant, 01 register with instruction amount, 1x register with register amount |
| sh_kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| imm_byte | input | 8 | Constant byte for the rotated-constant source |
| imm_rot | input | 4 | Rotate field; the rotation is twice this value |
| sh_imm | input | 5 | Shift amount field taken from the instruction |
| reg_val | input | 32 | Register value to shift |
| amt_reg | input | 32 | Register that supplies the shift amount in its low byte |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shifted, rotated or constant operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, an 8-bit constant, a 4-bit rotate field and an 8-bit register amount. The 8-bit register amount brings shifts of exactly 32, 33, the multiples of 32 and up to 255 within reach. These are where the overshift and modulo-rotate rules apply. The instruction-field sweeps cover every value from 0 to 31, so each zero encoding is exercised for every kind. A bit-serial reference model inside the bench predicts every result.

// File: rtl/opshift_pkg.sv
`timescale 1ns/1ps
package opshift_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shk_e;

    typedef enum logic [1:0] {
        SRC_ROTIMM  = 2'b00,
        SRC_IMMAMT  = 2'b01,
        SRC_REGAMT  = 2'b10,
        SRC_REGAMT2 = 2'b11
    } src_e;

    // decoded shift request handed to the barrel stage
    typedef struct packed {
        shk_e kind;
        logic rrx;
    } shop_t;

    function automatic logic src_is_reg_amount(input src_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/opshift_rotimm.sv
`timescale 1ns/1ps
module opshift_rotimm #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] value,
    output logic              carry
);
    localparam int RAMT_W = ROT_W + 1;
    localparam int EXT_W  = 2 * DATA_W;

    logic [RAMT_W-1:0] rot_amt;
    logic [DATA_W-1:0] base;
    logic [EXT_W-1:0]  doubled;

    assign rot_amt = {imm_rot, 1'b0};
    assign base    = DATA_W'(imm_byte);
    assign doubled = {base, base} >> rot_amt;

    always_comb begin
        value = doubled[DATA_W-1:0];
        carry = (imm_rot == '0) ? carry_in : doubled[DATA_W-1];
    end

    always_comb begin
        // R1: rotation never gains or loses set bits
        a_r1_bits_kept: assert ($countones(value) == $countones(imm_byte))
            else $error("rotated constant changed its population count");
        // R1: no rotation leaves the byte in the low lanes
        if (imm_rot == '0) begin
            a_r1_low_lanes: assert (value[DATA_W-1:IMM_W] == '0)
                else $error("unrotated constant spilled into upper bits");
        end
    end

endmodule

// File: rtl/opshift_amtsel.sv
`timescale 1ns/1ps
module opshift_amtsel
    import opshift_pkg::*;
#(
    parameter int AMT_W  = 5,
    parameter int RAMT_W = 8
) (
    input  src_e              src,
    input  shk_e              kind,
    input  logic [AMT_W-1:0]  sh_imm,
    input  logic [RAMT_W-1:0] amt_byte,
    output logic [RAMT_W-1:0] amount,
    output shop_t             op
);
    localparam logic [RAMT_W-1:0] FULL_AMT = RAMT_W'(1 << AMT_W);

    always_comb begin
        op.kind = kind;
        op.rrx  = 1'b0;
        amount  = amt_byte;
        if (!src_is_reg_amount(src)) begin
            amount = RAMT_W'(sh_imm);
            if (sh_imm == '0) begin
                unique case (kind)
                    SHK_LSR, SHK_ASR: amount = FULL_AMT;
                    SHK_ROR:          op.rrx = 1'b1;
                    default:          amount = '0;
                endcase
            end
        end
    end

    always_comb begin
        // R7: register amounts come from the low byte verbatim
        if (src_is_reg_amount(src)) begin
            a_r7_low_byte: assert (amount == amt_byte && !op.rrx)
                else $error("register amount not taken from low byte");
        end
        // R4: instruction right shifts always move by 1..32
        if (src == SRC_IMMAMT && (kind == SHK_LSR || kind == SHK_ASR)) begin
            a_r4_right_range: assert (amount != '0 && amount <= FULL_AMT)
                else $error("instruction right shift outside 1..32");
        end
    end

endmodule

// File: rtl/opshift_barrel.sv
`timescale 1ns/1ps
module opshift_barrel
    import opshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RAMT_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  shop_t             op,
    input  logic [RAMT_W-1:0] amount,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    localparam int AMT_W = $clog2(DATA_W);
    localparam int EXT_W = 2 * DATA_W;
    localparam logic [RAMT_W-1:0] FULL_AMT = RAMT_W'(DATA_W);
    localparam logic [RAMT_W-1:0] OVER_AMT = RAMT_W'(DATA_W + 1);

    logic [RAMT_W-1:0] amt_cap;
    logic [EXT_W-1:0]  lsl_t;
    logic [EXT_W-1:0]  lsr_t;
    logic [EXT_W-1:0]  asr_t;
    logic [EXT_W-1:0]  ror_t;

    // anything past one beyond the width behaves like one beyond it
    assign amt_cap = (amount > OVER_AMT) ? OVER_AMT : amount;
    assign lsl_t   = {{DATA_W{1'b0}}, data} << amt_cap;
    assign lsr_t   = {data, {DATA_W{1'b0}}} >> amt_cap;
    assign asr_t   = $signed({data, {DATA_W{1'b0}}}) >>> amt_cap;
    assign ror_t   = {data, data} >> amount[AMT_W-1:0];

    always_comb begin
        result = data;
        carry  = carry_in;
        if (op.rrx) begin
            result = {carry_in, data[DATA_W-1:1]};
            carry  = data[0];
        end else if (amount != '0) begin
            unique case (op.kind)
                SHK_LSL: begin
                    result = lsl_t[DATA_W-1:0];
                    carry  = lsl_t[DATA_W];
                end
                SHK_LSR: begin
                    result = lsr_t[EXT_W-1:DATA_W];
                    carry  = lsr_t[DATA_W-1];
                end
                SHK_ASR: begin
                    result = asr_t[EXT_W-1:DATA_W];
                    carry  = asr_t[DATA_W-1];
                end
                default: begin
                    result = ror_t[DATA_W-1:0];
                    carry  = ror_t[DATA_W-1];
                end
            endcase
        end
    end

    always_comb begin
        // R6: the rotate through carry moves exactly one bit each way
        if (op.rrx) begin
            a_r6_rrx_edges: assert (result[DATA_W-1] == carry_in && carry == data[0])
                else $error("rotate through carry edges wrong");
        end
        // R9: overshifted logical shifts clear everything
        if (!op.rrx && amount > FULL_AMT && (op.kind == SHK_LSL || op.kind == SHK_LSR)) begin
            a_r9_wide_zero: assert (result == '0 && !carry)
                else $error("overshift left residue");
        end
        // R10: wide arithmetic shift fills with the sign
        if (!op.rrx && amount >= FULL_AMT && op.kind == SHK_ASR) begin
            a_r10_sign_fill: assert ((result == '0 || result == '1)
                                     && result[0] == data[DATA_W-1] && carry == data[DATA_W-1])
                else $error("wide arithmetic shift not sign filled");
        end
        // R11: a rotation keeps every bit of the input
        if (!op.rrx && op.kind == SHK_ROR) begin
            a_r11_rot_keeps: assert ($countones(result) == $countones(data))
                else $error("rotation changed population count");
        end
    end

endmodule

// File: rtl/opshift_unit.sv
`timescale 1ns/1ps
module opshift_unit
    import opshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    parameter int RAMT_W = 8
) (
    input  logic [1:0]                 op_sel,
    input  logic [1:0]                 sh_kind,
    input  logic [IMM_W-1:0]           imm_byte,
    input  logic [ROT_W-1:0]           imm_rot,
    input  logic [$clog2(DATA_W)-1:0]  sh_imm,
    input  logic [DATA_W-1:0]          reg_val,
    input  logic [DATA_W-1:0]          amt_reg,
    input  logic                       carry_in,
    output logic [DATA_W-1:0]          operand,
    output logic                       carry_out
);
    localparam int AMT_W = $clog2(DATA_W);

    src_e              src;
    shk_e              kind;
    shop_t             op;
    logic [RAMT_W-1:0] amount;
    logic [DATA_W-1:0] rot_value;
    logic              rot_carry;
    logic [DATA_W-1:0] sh_value;
    logic              sh_carry;
    logic              amt_hi_unused;
    logic [AMT_W-1:0]  lsl_src_idx;

    assign src           = src_e'(op_sel);
    assign kind          = shk_e'(sh_kind);
    assign amt_hi_unused = ^amt_reg[DATA_W-1:RAMT_W];

    opshift_rotimm #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W)
    ) u_rotimm (
        .imm_byte (imm_byte),
        .imm_rot  (imm_rot),
        .carry_in (carry_in),
        .value    (rot_value),
        .carry    (rot_carry)
    );

    opshift_amtsel #(
        .AMT_W  (AMT_W),
        .RAMT_W (RAMT_W)
    ) u_amtsel (
        .src      (src),
        .kind     (kind),
        .sh_imm   (sh_imm),
        .amt_byte (amt_reg[RAMT_W-1:0]),
        .amount   (amount),
        .op       (op)
    );

    opshift_barrel #(
        .DATA_W (DATA_W),
        .RAMT_W (RAMT_W)
    ) u_barrel (
        .data     (reg_val),
        .op       (op),
        .amount   (amount),
        .carry_in (carry_in),
        .result   (sh_value),
        .carry    (sh_carry)
    );

    always_comb begin
        if (src == SRC_ROTIMM) begin
            operand   = rot_value;
            carry_out = rot_carry;
        end else begin
            operand   = sh_value;
            carry_out = sh_carry;
        end
    end

    assign lsl_src_idx = AMT_W'(DATA_W - int'(sh_imm));

    always_comb begin
        // R3: instruction left shift carries out the last bit leaving the top
        if (op_sel == 2'b01 && sh_kind == 2'b00 && sh_imm != '0) begin
            a_r3_lsl_carry: assert (carry_out == reg_val[lsl_src_idx])
                else $error("left shift carry is not the last bit shifted out");
        end
        // R2: an unrotated constant keeps the incoming carry
        if (op_sel == 2'b00 && imm_rot == '0) begin
            a_r2_carry_kept: assert (carry_out == carry_in)
                else $error("unrotated constant disturbed the carry");
        end
    end

endmodule

// File: tb/opshift_unit_tb.sv
`timescale 1ns/1ps
module opshift_unit_tb;

    logic        clk = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [1:0]  sh_kind = '0;
    logic [7:0]  imm_byte = '0;
    logic [3:0]  imm_rot = '0;
    logic [4:0]  sh_imm = '0;
    logic [31:0] reg_val = '0;
    logic [31:0] amt_reg = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    opshift_unit u_dut (
        .op_sel    (op_sel),
        .sh_kind   (sh_kind),
        .imm_byte  (imm_byte),
        .imm_rot   (imm_rot),
        .sh_imm    (sh_imm),
        .reg_val   (reg_val),
        .amt_reg   (amt_reg),
        .carry_in  (carry_in),
        .operand   (operand),
        .carry_out (carry_out)
    );

    // bit-serial reference written from the requirements
    function automatic void ref_model(
        input  logic [1:0]  sel, input logic [1:0] k, input logic [7:0] ib,
        input  logic [3:0]  rot, input logic [4:0] si, input logic [31:0] rv,
        input  logic [31:0] ar, input logic cin,
        output logic [31:0] v, output logic c);
        int n;
        logic rrx;
        if (sel == 2'b00) begin
            v = {24'b0, ib};
            c = cin;
            for (int i = 0; i < 2 * int'(rot); i++) v = {v[0], v[31:1]};
            if (rot != 0) c = v[31];
        end else begin
            rrx = 1'b0;
            n = (sel == 2'b01) ? int'(si) : int'(ar[7:0]);
            if (sel == 2'b01 && si == 0) begin
                if (k == 2'b01 || k == 2'b10) n = 32;
                if (k == 2'b11) rrx = 1'b1;
            end
            v = rv;
            c = cin;
            if (rrx) begin
                c = rv[0];
                v = {cin, rv[31:1]};
            end else begin
                for (int i = 0; i < n; i++) begin
                    case (k)
                        2'b00: begin c = v[31]; v = v << 1; end
                        2'b01: begin c = v[0]; v = v >> 1; end
                        2'b10: begin c = v[0]; v = {v[31], v[31:1]}; end
                        default: begin c = v[0]; v = {v[0], v[31:1]}; end
                    endcase
                end
            end
        end
    endfunction

    task automatic drive(input logic [1:0] sel, input logic [1:0] k, input logic [7:0] ib,
                         input logic [3:0] rot, input logic [4:0] si, input logic [31:0] rv,
                         input logic [31:0] ar, input logic cin);
        @(posedge clk);
        #2;
        op_sel = sel; sh_kind = k; imm_byte = ib; imm_rot = rot;
        sh_imm = si; reg_val = rv; amt_reg = ar; carry_in = cin;
        #2;
    endtask

    task automatic compare(input string tag, input logic [31:0] ev, input logic ec);
        checks++;
        if (operand !== ev || carry_out !== ec) begin
            errors++;
            $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                     tag, operand, carry_out, ev, ec);
        end
    endtask

    task automatic lit(input string tag, input logic [1:0] sel, input logic [1:0] k,
                       input logic [7:0] ib, input logic [3:0] rot, input logic [4:0] si,
                       input logic [31:0] rv, input logic [31:0] ar, input logic cin,
                       input logic [31:0] ev, input logic ec);
        drive(sel, k, ib, rot, si, rv, ar, cin);
        compare(tag, ev, ec);
    endtask

    task automatic mdl(input string tag, input logic [1:0] sel, input logic [1:0] k,
                       input logic [7:0] ib, input logic [3:0] rot, input logic [4:0] si,
                       input logic [31:0] rv, input logic [31:0] ar, input logic cin);
        logic [31:0] ev;
        logic ec;
        ref_model(sel, k, ib, rot, si, rv, ar, cin, ev, ec);
        drive(sel, k, ib, rot, si, rv, ar, cin);
        compare(tag, ev, ec);
    endtask

    task automatic t_idle();
        lit("R2 idle", 2'b00, 2'b00, 8'h00, 4'd0, 5'd0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0);
        lit("R2 idle carry", 2'b00, 2'b00, 8'h00, 4'd0, 5'd0, 32'h0, 32'h0, 1'b1, 32'h0, 1'b1);
    endtask

    task automatic t_rot_imm();
        lit("R1", 2'b00, 2'b00, 8'hFF, 4'd4, 5'd0, 32'h0, 32'h0, 1'b0, 32'hFF000000, 1'b1);
        lit("R1", 2'b00, 2'b00, 8'h3F, 4'd1, 5'd0, 32'h0, 32'h0, 1'b0, 32'hC000000F, 1'b1);
        lit("R2", 2'b00, 2'b00, 8'h01, 4'd1, 5'd0, 32'h0, 32'h0, 1'b1, 32'h40000000, 1'b0);
        for (int r = 0; r < 16; r++) begin
            mdl("R1", 2'b00, 2'b00, 8'hA5, 4'(r), 5'd0, 32'hDEADBEEF, 32'h0, 1'(r));
            mdl("R2", 2'b00, 2'b00, 8'h81, 4'(r), 5'd0, 32'h0, 32'h0, 1'(r + 1));
        end
    endtask

    task automatic t_imm_lsl();
        lit("R3 zero", 2'b01, 2'b00, 8'h0, 4'd0, 5'd0, 32'h80000001, 32'h0, 1'b1, 32'h80000001, 1'b1);
        lit("R3", 2'b01, 2'b00, 8'h0, 4'd0, 5'd1, 32'h80000001, 32'h0, 1'b0, 32'h00000002, 1'b1);
        lit("R3", 2'b01, 2'b00, 8'h0, 4'd0, 5'd31, 32'h00000003, 32'h0, 1'b0, 32'h80000000, 1'b1);
        for (int s = 0; s < 32; s++)
            mdl("R3", 2'b01, 2'b00, 8'h0, 4'd0, 5'(s), 32'hC3A5_5A3C, 32'h0, 1'(s));
    endtask

    task automatic t_imm_right();
        lit("R4 lsr32", 2'b01, 2'b01, 8'h0, 4'd0, 5'd0, 32'h80000000, 32'h0, 1'b0, 32'h0, 1'b1);
        lit("R4 asr32", 2'b01, 2'b10, 8'h0, 4'd0, 5'd0, 32'h80000000, 32'h0, 1'b0, 32'hFFFFFFFF, 1'b1);
        lit("R4 asr32 pos", 2'b01, 2'b10, 8'h0, 4'd0, 5'd0, 32'h7FFFFFFF, 32'h0, 1'b1, 32'h0, 1'b0);
        lit("R4", 2'b01, 2'b01, 8'h0, 4'd0, 5'd4, 32'h000000F8, 32'h0, 1'b0, 32'h0000000F, 1'b1);
        for (int s = 0; s < 32; s++) begin
            mdl("R4 lsr", 2'b01, 2'b01, 8'h0, 4'd0, 5'(s), 32'h9E37_79B9, 32'h0, 1'(s));
            mdl("R4 asr", 2'b01, 2'b10, 8'h0, 4'd0, 5'(s), 32'h9E37_79B9, 32'h0, 1'(s));
        end
    endtask

    task automatic t_imm_ror();
        lit("R5", 2'b01, 2'b11, 8'h0, 4'd0, 5'd8, 32'h12345678, 32'h0, 1'b1, 32'h78123456, 1'b0);
        lit("R6", 2'b01, 2'b11, 8'h0, 4'd0, 5'd0, 32'h00000003, 32'h0, 1'b1, 32'h80000001, 1'b1);
        lit("R6", 2'b01, 2'b11, 8'h0, 4'd0, 5'd0, 32'h00000002, 32'h0, 1'b0, 32'h00000001, 1'b0);
        for (int s = 1; s < 32; s++)
            mdl("R5", 2'b01, 2'b11, 8'h0, 4'd0, 5'(s), 32'h0F1E_2D3C, 32'h0, 1'b0);
    endtask

    task automatic t_reg_amount();
        lit("R7", 2'b10, 2'b00, 8'hFF, 4'd7, 5'd9, 32'h00000011, 32'hFFFFFF04, 1'b0, 32'h00000110, 1'b0);
        lit("R7 hi", 2'b10, 2'b00, 8'h0, 4'd0, 5'd0, 32'h00000011, 32'h00000104, 1'b0, 32'h00000110, 1'b0);
        for (int k = 0; k < 4; k++)
            lit("R8", 2'b10, 2'(k), 8'h0, 4'd0, 5'd3, 32'hA5A5_0F0F, 32'hABCD_0100, 1'b1, 32'hA5A5_0F0F, 1'b1);
        lit("R9 lsl32", 2'b10, 2'b00, 8'h0, 4'd0, 5'd0, 32'h00000001, 32'd32, 1'b0, 32'h0, 1'b1);
        lit("R9 lsl33", 2'b10, 2'b00, 8'h0, 4'd0, 5'd0, 32'hFFFFFFFF, 32'd33, 1'b1, 32'h0, 1'b0);
        lit("R9 lsr32", 2'b10, 2'b01, 8'h0, 4'd0, 5'd0, 32'h80000000, 32'd32, 1'b0, 32'h0, 1'b1);
        lit("R9 lsr200", 2'b10, 2'b01, 8'h0, 4'd0, 5'd0, 32'hFFFFFFFF, 32'd200, 1'b1, 32'h0, 1'b0);
        lit("R10 asr32", 2'b10, 2'b10, 8'h0, 4'd0, 5'd0, 32'h80000000, 32'd32, 1'b0, 32'hFFFFFFFF, 1'b1);
        lit("R10 asr255", 2'b10, 2'b10, 8'h0, 4'd0, 5'd0, 32'h40000000, 32'd255, 1'b1, 32'h0, 1'b0);
        lit("R11 ror32", 2'b10, 2'b11, 8'h0, 4'd0, 5'd0, 32'h80000001, 32'd32, 1'b0, 32'h80000001, 1'b1);
        lit("R11 ror36", 2'b10, 2'b11, 8'h0, 4'd0, 5'd0, 32'h0000000F, 32'd36, 1'b0, 32'hF0000000, 1'b1);
        lit("R11 ror64", 2'b10, 2'b11, 8'h0, 4'd0, 5'd0, 32'h7FFFFFFF, 32'd64, 1'b1, 32'h7FFFFFFF, 1'b0);
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 70; a++)
                mdl("R9 R10 R11 sweep", 2'b10, 2'(k), 8'h0, 4'd0, 5'd0, 32'hB38F_01C6,
                    32'(a), 1'(a));
    endtask

    task automatic t_src_sel();
        mdl("R7 sel3", 2'b11, 2'b01, 8'h55, 4'd3, 5'd17, 32'hF00D_CAFE, 32'h0000_0005, 1'b1);
        lit("R7 sel3", 2'b11, 2'b01, 8'h55, 4'd3, 5'd17, 32'hF00D_CAFE, 32'h0000_0005, 1'b1,
            32'h07806E57, 1'b1);
        lit("R1 ignores reg", 2'b00, 2'b11, 8'h80, 4'd0, 5'd5, 32'hFFFFFFFF, 32'd7, 1'b0,
            32'h00000080, 1'b0);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_idle();
        t_rot_imm();
        t_imm_lsl();
        t_imm_right();
        t_imm_ror();
        t_reg_amount();
        t_src_sel();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule